// File: doc/BRIEF.md
# Single-Cycle Subset Processor Core

This block is a 32-bit processor core that finishes every instruction in one clock period. It supports a small load/store subset: word load, word store, the five register-to-register operations (add, subtract, AND, OR and signed set-less-than), branch-if-equal, and an absolute jump. In a single cycle the core fetches from its internal instruction array, decodes the instruction, reads two registers, runs the ALU, accesses its internal data array, and writes a register back.

Control is decoded in two levels. A main decoder turns the 6-bit opcode into single-bit steering lines and a 2-bit operation class. A second decoder turns that class, together with the function field for register-to-register instructions, into the 4-bit ALU command. The branch is taken only when the branch line from the main decoder and the ALU zero flag are both high.

The only ports are a clock and a synchronous reset. Programs and operands are placed in the instruction and data word arrays while reset is held. Results are read back from the data array.

Top module: `sc_core`

## Requirements
- R1: While reset is high the PC is 0. After reset is released, each edge that executes a non-branching instruction advances the PC by 4. Instruction word k is fetched from byte address 4k.
- R2: An instruction with opcode 000000 writes register rd with rs op rt. The operation is chosen by the function field: 100000 add, 100010 subtract, 100100 AND, 100101 OR, 101010 signed set-less-than, which gives 1 or 0.
- R3: Opcode 100011 loads register rt with the data word at byte address rs plus the 16-bit offset in bits 15:0, sign-extended from bit 15.
- R4: Opcode 101011 stores register rt to the data word at byte address rs plus the sign-extended offset. Negative offsets are supported.
- R5: Opcode 000100 compares rs and rt. When they are equal, the next PC is PC+4 plus the sign-extended offset shifted left by 2, and the offset may be negative. When they differ, the next PC is PC+4.
- R6: Opcode 000010 sets the next PC to bits 31:28 of PC+4, followed by the 26-bit index in bits 25:0, followed by two zero bits.
- R7: Register 0 always reads as zero. Writes to register 0 are discarded.
- R8: Any opcode other than the five above writes no register and no data word, and the PC advances by 4.
- R9: A register written by one instruction holds the new value for the very next instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset: PC and registers to 0, writes held off |

## Verification
The bench sweeps all five register-to-register operations over operand pairs that include zero, all-ones, the largest positive value and the most negative value. A core with an unsigned set-less-than, or with a swapped function code, returns a wrong word for some pair.

A branch program traces the PC edge by edge through a taken forward branch, an untaken branch, a jump and a backward self-branch. A wrong shift or a missing +4 in either target sends the PC to another address, and a skipped store then appears in memory.

A second program covers negative load and store offsets, a read of a register right after its write, a write aimed at register 0, and two unassigned opcodes whose other fields look like a store and a load. A core that leaks writes for those opcodes corrupts a watched data word or register.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned REG_CNT = 32;
    localparam int unsigned REG_AW = $clog2(REG_CNT);

    localparam logic [5:0] OPC_RTYPE = 6'b000000;
    localparam logic [5:0] OPC_JUMP  = 6'b000010;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [1:0] {
        CLS_ADDR = 2'b00,
        CLS_CMP  = 2'b01,
        CLS_FUNC = 2'b10
    } op_class_e;

    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111
    } alu_cmd_e;

    typedef struct packed {
        logic      dst_is_rd;
        logic      b_is_imm;
        logic      wb_from_mem;
        logic      reg_wr;
        logic      mem_rd;
        logic      mem_wr;
        logic      branch;
        logic      jump;
        op_class_e op_class;
    } ctrl_t;

    function automatic logic [WORD_W-1:0] sext16(input logic [15:0] v);
        return {{(WORD_W-16){v[15]}}, v};
    endfunction

    function automatic logic op_is_known(input logic [5:0] op);
        return (op == OPC_RTYPE) || (op == OPC_JUMP) || (op == OPC_BEQ) ||
               (op == OPC_LOAD) || (op == OPC_STORE);
    endfunction

endpackage

// File: rtl/sc_main_decode.sv
module sc_main_decode
    import sc_core_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctl
);
    always_comb begin
        ctl = '0;
        ctl.op_class = CLS_ADDR;
        unique case (opcode)
            OPC_RTYPE: begin
                ctl.dst_is_rd = 1'b1;
                ctl.reg_wr    = 1'b1;
                ctl.op_class  = CLS_FUNC;
            end
            OPC_LOAD: begin
                ctl.b_is_imm    = 1'b1;
                ctl.wb_from_mem = 1'b1;
                ctl.reg_wr      = 1'b1;
                ctl.mem_rd      = 1'b1;
            end
            OPC_STORE: begin
                ctl.b_is_imm = 1'b1;
                ctl.mem_wr   = 1'b1;
            end
            OPC_BEQ: begin
                ctl.branch   = 1'b1;
                ctl.op_class = CLS_CMP;
            end
            OPC_JUMP: begin
                ctl.jump = 1'b1;
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/sc_alu_decode.sv
module sc_alu_decode
    import sc_core_pkg::*;
(
    input  op_class_e op_class,
    input  logic [5:0] funct,
    output alu_cmd_e   cmd
);
    always_comb begin
        cmd = ALU_ADD;
        case (op_class)
            CLS_ADDR: cmd = ALU_ADD;
            CLS_CMP:  cmd = ALU_SUB;
            default: begin
                case (funct)
                    FN_SUB:  cmd = ALU_SUB;
                    FN_AND:  cmd = ALU_AND;
                    FN_OR:   cmd = ALU_OR;
                    FN_SLT:  cmd = ALU_SLT;
                    default: cmd = ALU_ADD;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_core_pkg::*;
(
    input  alu_cmd_e          cmd,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic [WORD_W-1:0] y,
    output logic              zero
);
    always_comb begin
        case (cmd)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(WORD_W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end
    assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_core_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] raddr_a,
    input  logic [REG_AW-1:0] raddr_b,
    output logic [WORD_W-1:0] rdata_a,
    output logic [WORD_W-1:0] rdata_b,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  logic [WORD_W-1:0] wdata
);
    logic [WORD_W-1:0] regs [REG_CNT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_CNT; i++) regs[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

    // R9: a write is visible to the next cycle's reads
    assert_wr_visible_R9: assert property (@(posedge clk) disable iff (rst)
        (we && (waddr != '0)) |=> (regs[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_core_pkg::*;
#(
    parameter int unsigned IMEM_WORDS = 64,
    parameter int unsigned DMEM_WORDS = 64
) (
    input logic clk,
    input logic rst
);
    localparam int unsigned IA = $clog2(IMEM_WORDS);
    localparam int unsigned DA = $clog2(DMEM_WORDS);

    logic [WORD_W-1:0] imem [IMEM_WORDS];
    logic [WORD_W-1:0] dmem [DMEM_WORDS];

    initial begin
        for (int i = 0; i < IMEM_WORDS; i++) imem[i] = '0;
    end

    logic [WORD_W-1:0] pc_r, pc_plus4, pc_next, instr;
    logic [WORD_W-1:0] imm_ext, br_target, jmp_target;
    logic [WORD_W-1:0] rs_val, rt_val, alu_b, alu_res, mem_rdata, wb_data;
    logic [REG_AW-1:0] wr_sel;
    logic [DA-1:0]     dm_idx;
    logic              alu_zero, pc_src, op_known;
    ctrl_t             ctl;
    alu_cmd_e          alu_cmd;

    // fetch
    assign instr    = imem[pc_r[IA+1:2]];
    assign pc_plus4 = pc_r + 32'd4;

    // decode
    sc_main_decode u_main (.opcode(instr[31:26]), .ctl(ctl));
    sc_alu_decode  u_aluc (.op_class(ctl.op_class), .funct(instr[5:0]), .cmd(alu_cmd));
    assign op_known = op_is_known(instr[31:26]);

    assign imm_ext = sext16(instr[15:0]);
    assign wr_sel  = ctl.dst_is_rd ? instr[15:11] : instr[20:16];

    sc_regfile u_rf (
        .clk(clk), .rst(rst),
        .raddr_a(instr[25:21]), .raddr_b(instr[20:16]),
        .rdata_a(rs_val), .rdata_b(rt_val),
        .we(ctl.reg_wr & ~rst), .waddr(wr_sel), .wdata(wb_data)
    );

    // execute
    assign alu_b = ctl.b_is_imm ? imm_ext : rt_val;
    sc_alu u_alu (.cmd(alu_cmd), .a(rs_val), .b(alu_b), .y(alu_res), .zero(alu_zero));

    // memory
    assign dm_idx    = alu_res[DA+1:2];
    assign mem_rdata = ctl.mem_rd ? dmem[dm_idx] : '0;
    always_ff @(posedge clk) begin
        if (!rst && ctl.mem_wr) dmem[dm_idx] <= rt_val;
    end

    // writeback
    assign wb_data = ctl.wb_from_mem ? mem_rdata : alu_res;

    // next PC
    assign br_target  = pc_plus4 + {imm_ext[WORD_W-3:0], 2'b00};
    assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};
    assign pc_src     = ctl.branch & alu_zero;
    assign pc_next    = ctl.jump ? jmp_target : (pc_src ? br_target : pc_plus4);

    always_ff @(posedge clk) begin
        if (rst) pc_r <= '0;
        else     pc_r <= pc_next;
    end

    // R1: PC leaves reset at zero
    assert_pc_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc_r == '0));
    // R1: sequential advance by 4
    assert_pc_step_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!ctl.branch && !ctl.jump)) |-> (pc_r == $past(pc_r) + 32'd4));
    // R3: load address is base plus extended offset
    assert_load_addr_R3: assert property (@(posedge clk) disable iff (rst)
        ctl.mem_rd |-> (alu_res == rs_val + sext16(instr[15:0])));
    // R4: stored word lands in the addressed entry
    assert_store_lands_R4: assert property (@(posedge clk) disable iff (rst)
        ctl.mem_wr |=> (dmem[$past(dm_idx)] == $past(rt_val)));
    // R5: a taken branch only on equal operands
    assert_br_equal_R5: assert property (@(posedge clk) disable iff (rst)
        pc_src |-> (rs_val == rt_val));
    // R5: taken branch reaches its target
    assert_br_target_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(pc_src) && $past(!ctl.jump)) |-> (pc_r == $past(br_target)));
    // R8: unassigned opcode only advances the PC
    assert_unknown_op_R8: assert property (@(posedge clk) disable iff (rst)
        !op_known |-> (!ctl.reg_wr && !ctl.mem_wr));
    // usage: data accesses are aligned and inside the array
    assert_mem_in_range: assert property (@(posedge clk) disable iff (rst)
        (ctl.mem_rd || ctl.mem_wr) |-> ((alu_res[1:0] == 2'b00) && ((alu_res >> (DA + 2)) == '0)));
endmodule

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sc_core uut (.clk(clk), .rst(rst));

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'b00000, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction
    function automatic logic [31:0] enc_j(int idx);
        return {6'b000010, idx[25:0]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 64; i++) begin
            uut.imem[i] = 32'h0;
            uut.dmem[i] = 32'h0;
        end
        @(negedge clk);
    endtask

    task automatic release_reset();
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [31:0] model(logic [5:0] fn, logic [31:0] a, logic [31:0] b);
        case (fn)
            6'b100000: return a + b;
            6'b100010: return a - b;
            6'b100100: return a & b;
            6'b100101: return a | b;
            default:   return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        endcase
    endfunction

    logic [31:0] vals [6] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h1234_ABCD};
    logic [5:0]  fns  [5] = '{6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010};

    initial begin
        int seq [9] = '{0, 4, 8, 16, 20, 24, 40, 44, 44};

        // Sweep of register-register operations (R2, R3, R4)
        for (int f = 0; f < 5; f++) begin
            for (int x = 0; x < 6; x++) begin
                for (int y = 0; y < 6; y++) begin
                    hold_reset();
                    if (f == 0 && x == 0 && y == 0) check("R1 pc in reset", uut.pc_r, 32'h0);
                    uut.dmem[0] = vals[x];
                    uut.dmem[1] = vals[y];
                    uut.imem[0] = enc_i(6'b100011, 0, 1, 0);
                    uut.imem[1] = enc_i(6'b100011, 0, 2, 4);
                    uut.imem[2] = enc_r(1, 2, 3, fns[f]);
                    uut.imem[3] = enc_i(6'b101011, 0, 3, 8);
                    uut.imem[4] = enc_j(4);
                    release_reset();
                    repeat (6) @(negedge clk);
                    check("R2 alu result", uut.dmem[2], model(fns[f], vals[x], vals[y]));
                end
            end
        end

        // Branch and jump trace (R1, R5, R6)
        hold_reset();
        uut.dmem[0] = 32'd5;
        uut.dmem[1] = 32'd5;
        uut.imem[0]  = enc_i(6'b100011, 0, 1, 0);
        uut.imem[1]  = enc_i(6'b100011, 0, 2, 4);
        uut.imem[2]  = enc_i(6'b000100, 1, 2, 1);
        uut.imem[3]  = enc_i(6'b101011, 0, 1, 8);
        uut.imem[4]  = enc_i(6'b000100, 1, 0, 1);
        uut.imem[5]  = enc_i(6'b101011, 0, 2, 12);
        uut.imem[6]  = enc_j(10);
        uut.imem[7]  = enc_i(6'b101011, 0, 1, 16);
        uut.imem[10] = enc_i(6'b101011, 0, 2, 20);
        uut.imem[11] = enc_i(6'b000100, 0, 0, -1);
        release_reset();
        check("R1 pc after reset", uut.pc_r, 32'h0);
        for (int k = 1; k < 9; k++) begin
            @(negedge clk);
            check("R5 R6 pc trace", uut.pc_r, seq[k]);
        end
        check("R5 taken branch skipped store", uut.dmem[2], 32'h0);
        check("R5 untaken branch falls through", uut.dmem[3], 32'd5);
        check("R6 jump skipped store", uut.dmem[4], 32'h0);
        check("R6 jump target executed", uut.dmem[5], 32'd5);

        // Offsets, RAW, register 0, unknown opcodes (R3, R4, R7, R8, R9)
        hold_reset();
        uut.dmem[0]  = 32'd44;
        uut.dmem[3]  = 32'hDEAD;
        uut.dmem[10] = 32'h55;
        uut.dmem[12] = 32'h77;
        uut.imem[0]  = enc_i(6'b100011, 0, 4, 0);
        uut.imem[1]  = enc_i(6'b100011, 4, 3, -4);
        uut.imem[2]  = enc_r(3, 3, 5, 6'b100000);
        uut.imem[3]  = enc_i(6'b101011, 4, 3, -8);
        uut.imem[4]  = enc_i(6'b101011, 0, 5, 4);
        uut.imem[5]  = enc_r(4, 4, 0, 6'b100000);
        uut.imem[6]  = enc_i(6'b101011, 0, 0, 12);
        uut.imem[7]  = enc_i(6'b101111, 0, 4, 48);
        uut.imem[8]  = enc_i(6'b100111, 0, 5, 0);
        uut.imem[9]  = enc_i(6'b101011, 0, 5, 8);
        uut.imem[10] = enc_i(6'b000100, 0, 0, -1);
        release_reset();
        repeat (8) @(negedge clk);
        check("R8 pc advances past unknown op", uut.pc_r, 32'd32);
        repeat (6) @(negedge clk);
        check("R1 backward self loop", uut.pc_r, 32'd40);
        check("R3 R4 negative offsets", uut.dmem[9], 32'h55);
        check("R9 read after write", uut.dmem[1], 32'hAA);
        check("R7 register 0 stays zero", uut.dmem[3], 32'h0);
        check("R8 no store from unknown op", uut.dmem[12], 32'h77);
        check("R8 no register write from unknown op", uut.dmem[2], 32'hAA);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule